// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block places a 32 by 32 pixel cursor over a stream of RGB pixels. Each cursor pixel is described by a 2-bit code held in a 256-byte bitmap. The code picks one of two cursor colours, lets the input pixel through, or applies a special action. The mode bit decides whether that special action inverts the input pixel or shows an auxiliary colour. The engine compares each incoming pixel coordinate against the cursor window and rewrites the pixel when it falls inside. The result appears one clock after the pixel was presented.

The cursor is placed by its hot spot. A register pair gives the hot spot's location inside the bitmap, and a second pair gives the screen coordinate where that hot spot should appear. The bitmap's upper-left corner on screen is the position minus the hot spot. That corner is clamped to zero so the cursor never wraps off the left or top edge. On the right and bottom it may run past the last coordinate and is simply cut off there. All bitmap bytes and registers are loaded through one byte/word write port.

Top module: `cursor_overlay`

## Requirements
- R1: A synchronous active-low reset clears `out_valid`, all three colours, both hot-spot coordinates, both position coordinates and the mode bit to zero. The bitmap is not cleared.
- R2: Every pixel accepted with `pix_valid` high yields exactly one result with `out_valid` high on the next clock. `out_valid` stays low in every other cycle.
- R3: A pixel outside the 32x32 cursor window leaves the block unchanged.
- R4: Inside the window, column c and row r (relative to the window corner) take their code from bitmap byte r*8 + c/4. The code sits in bits 2*(c%4)+1 down to 2*(c%4) of that byte.
- R5: Code 00 outputs the second cursor colour, and code 01 outputs the first cursor colour.
- R6: Code 10 outputs the input pixel unchanged.
- R7: Code 11 with mode bit 0 outputs the bitwise complement of each 8-bit R, G and B component of the input pixel.
- R8: Code 11 with mode bit 1 outputs the auxiliary cursor colour.
- R9: The window corner is position minus hot spot, on each axis. A pixel at the position coordinate therefore uses the bitmap entry at the hot spot.
- R10: On any axis where the position is smaller than the hot spot, the window corner on that axis is 0.
- R11: A window that extends past the largest coordinate is clipped and does not wrap. Pixels at small coordinates are never covered by a window whose corner lies near the top of the coordinate range.
- R12: A pixel that looks up a bitmap byte on the same clock that byte is written sees the old content. The new content applies from the next pixel onward.
- R13: The write address and data are decoded as follows.
  - With `cfg_addr[8]` = 0, byte `cfg_addr[7:0]` of the bitmap receives `cfg_wdata[7:0]`.
  - With `cfg_addr[8]` = 1 and `cfg_addr[7:3]` = 0, `cfg_addr[2:0]` selects a register:
    - 0: first colour.
    - 1: second colour.
    - 2: auxiliary colour.
    - 3: hot spot, with x in `cfg_wdata[4:0]` and y in `cfg_wdata[12:8]`.
    - 4: position x, in `cfg_wdata[11:0]`.
    - 5: position y, in `cfg_wdata[11:0]`.
    - 6: mode, in `cfg_wdata[0]`.
  - A colour value is R in bits 23:16, G in bits 15:8 and B in bits 7:0. The same layout applies to `pix_rgb` and `out_rgb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for bitmap and registers |
| cfg_addr | input | 9 | Write address (bitmap byte or register index) |
| cfg_wdata | input | 24 | Write data |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_x | input | 12 | Input pixel column |
| pix_y | input | 12 | Input pixel row |
| pix_rgb | input | 24 | Input pixel colour |
| out_valid | output | 1 | Output pixel qualifier |
| out_rgb | output | 24 | Overlaid pixel colour |

## Verification
A bitmap write and a pixel lookup can land on the same clock edge. This is the one place where two functions meet in one cycle. The bench provokes it by presenting a pixel inside the cursor while it writes the very byte that pixel reads, in the same cycle. It then presents the same pixel again on the following clock. The first result must carry the colour selected by the old code and the second the colour selected by the new code, both predicted from a shadow copy of the bitmap that is updated only after the edge.

// File: rtl/cursor_pkg.sv
// Shared constants and types for the cursor overlay engine.
// Assumes 8-bit colour components and a square bitmap with 2-bit codes.
package cursor_pkg;
    localparam int COMP_W        = 8;
    localparam int NUM_COMP      = 3;
    localparam int RGB_W         = COMP_W * NUM_COMP;
    localparam int CUR_DIM       = 32;
    localparam int CODE_W        = 2;
    localparam int BYTE_W        = 8;
    localparam int PIX_PER_BYTE  = BYTE_W / CODE_W;
    localparam int BYTES_PER_ROW = CUR_DIM / PIX_PER_BYTE;
    localparam int BMP_BYTES     = CUR_DIM * BYTES_PER_ROW;
    localparam int BMP_AW        = $clog2(BMP_BYTES);
    localparam int DIM_W         = $clog2(CUR_DIM);
    localparam int SEL_W         = $clog2(PIX_PER_BYTE);
    localparam int REG_AW        = 3;
    localparam int CFG_AW        = BMP_AW + 1;
    localparam int HOT_Y_LSB     = 8;

    typedef enum logic [CODE_W-1:0] {
        CODE_SECOND  = 2'b00,
        CODE_FIRST   = 2'b01,
        CODE_CLEAR   = 2'b10,
        CODE_SPECIAL = 2'b11
    } code_e;

    typedef enum logic [REG_AW-1:0] {
        REG_COL_FIRST  = 3'd0,
        REG_COL_SECOND = 3'd1,
        REG_COL_AUX    = 3'd2,
        REG_HOT        = 3'd3,
        REG_POS_X      = 3'd4,
        REG_POS_Y      = 3'd5,
        REG_MODE       = 3'd6
    } reg_e;
endpackage

// File: rtl/cursor_regs.sv
// Control registers of the cursor engine: three colours, hot spot,
// position and mode bit. Written through the shared configuration port
// when the top address bit is set and the middle address bits are zero.
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [RGB_W-1:0]   cfg_wdata,
    output logic [RGB_W-1:0]   col_first,
    output logic [RGB_W-1:0]   col_second,
    output logic [RGB_W-1:0]   col_aux,
    output logic [DIM_W-1:0]   hot_x,
    output logic [DIM_W-1:0]   hot_y,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic               mode
);
    logic reg_hit;

    // Decode a register write: top bit set, gap bits clear.
    always_comb begin
        reg_hit = cfg_we && cfg_addr[CFG_AW-1]
                  && (cfg_addr[CFG_AW-2:REG_AW] == '0);
    end

    // Update the addressed register; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_first  <= '0;
            col_second <= '0;
            col_aux    <= '0;
            hot_x      <= '0;
            hot_y      <= '0;
            pos_x      <= '0;
            pos_y      <= '0;
            mode       <= 1'b0;
        end else if (reg_hit) begin
            case (reg_e'(cfg_addr[REG_AW-1:0]))
                REG_COL_FIRST:  col_first  <= cfg_wdata;
                REG_COL_SECOND: col_second <= cfg_wdata;
                REG_COL_AUX:    col_aux    <= cfg_wdata;
                REG_HOT: begin
                    hot_x <= cfg_wdata[DIM_W-1:0];
                    hot_y <= cfg_wdata[HOT_Y_LSB +: DIM_W];
                end
                REG_POS_X:      pos_x <= cfg_wdata[COORD_W-1:0];
                REG_POS_Y:      pos_y <= cfg_wdata[COORD_W-1:0];
                REG_MODE:       mode  <= cfg_wdata[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cursor_bitmap.sv
// Cursor bitmap storage: one write port, one synchronous read port.
// A read and a write to the same byte on one edge return the old byte.
// The array and the read register carry no reset so they map onto RAM.
module cursor_bitmap
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [BMP_AW-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              re,
    input  logic [BMP_AW-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem [BMP_BYTES];

    // Store a configuration byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the byte the current pixel needs (read-before-write).
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/cursor_locate.sv
// Window locator: derives the clamped cursor corner from position and
// hot spot, tests each pixel against the 32x32 window without wraparound,
// forms the bitmap byte address, and registers the pixel context for the
// output stage. Assumes COORD_W is wider than DIM_W.
module cursor_locate
    import cursor_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [RGB_W-1:0]   pix_rgb,
    input  logic [DIM_W-1:0]   hot_x,
    input  logic [DIM_W-1:0]   hot_y,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    output logic [BMP_AW-1:0]  rd_addr,
    output logic               valid_q,
    output logic               hit_q,
    output logic [SEL_W-1:0]   sel_q,
    output logic [RGB_W-1:0]   rgb_q
);
    localparam int PAD_W = COORD_W - DIM_W;

    logic [COORD_W-1:0] hx, hy, org_x, org_y, dx, dy;
    logic               in_x, in_y;
    logic [DIM_W-1:0]   col, row;

    // Clamp the window corner at zero on the left and top edges.
    always_comb begin
        hx    = {{PAD_W{1'b0}}, hot_x};
        hy    = {{PAD_W{1'b0}}, hot_y};
        org_x = (pos_x >= hx) ? (pos_x - hx) : '0;
        org_y = (pos_y >= hy) ? (pos_y - hy) : '0;
    end

    // Offset inside the window; compare first so nothing wraps.
    always_comb begin
        dx   = pix_x - org_x;
        dy   = pix_y - org_y;
        in_x = (pix_x >= org_x) && (dx < COORD_W'(CUR_DIM));
        in_y = (pix_y >= org_y) && (dy < COORD_W'(CUR_DIM));
        col  = dx[DIM_W-1:0];
        row  = dy[DIM_W-1:0];
        rd_addr = {row, col[DIM_W-1:SEL_W]};
    end

    // Carry the pixel and its window status to the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            hit_q   <= 1'b0;
            sel_q   <= '0;
            rgb_q   <= '0;
        end else begin
            valid_q <= pix_valid;
            hit_q   <= pix_valid && in_x && in_y;
            if (pix_valid) begin
                sel_q <= col[SEL_W-1:0];
                rgb_q <= pix_rgb;
            end
        end
    end
endmodule

// File: rtl/cursor_blend.sv
// Output mixer: picks the 2-bit code of the current pixel out of the
// fetched bitmap byte and applies it to the pixel. Purely combinational;
// a pixel outside the window is always passed through.
module cursor_blend
    import cursor_pkg::*;
(
    input  logic              hit,
    input  logic              mode,
    input  logic [BYTE_W-1:0] bmp_byte,
    input  logic [SEL_W-1:0]  sel,
    input  logic [RGB_W-1:0]  rgb_in,
    input  logic [RGB_W-1:0]  col_first,
    input  logic [RGB_W-1:0]  col_second,
    input  logic [RGB_W-1:0]  col_aux,
    output code_e             code,
    output logic [RGB_W-1:0]  rgb_out
);
    logic [CODE_W-1:0] field [PIX_PER_BYTE];
    logic [RGB_W-1:0]  inv;

    // Split the byte into codes, lowest column in the lowest bits.
    for (genvar gi = 0; gi < PIX_PER_BYTE; gi++) begin : g_field
        assign field[gi] = bmp_byte[gi*CODE_W +: CODE_W];
    end

    // Complement each colour component separately.
    for (genvar gc = 0; gc < NUM_COMP; gc++) begin : g_inv
        assign inv[gc*COMP_W +: COMP_W] = ~rgb_in[gc*COMP_W +: COMP_W];
    end

    assign code = code_e'(field[sel]);

    // Choose the output colour from the code and the mode bit.
    always_comb begin
        rgb_out = rgb_in;
        if (hit) begin
            case (code)
                CODE_SECOND:  rgb_out = col_second;
                CODE_FIRST:   rgb_out = col_first;
                CODE_CLEAR:   rgb_out = rgb_in;
                CODE_SPECIAL: rgb_out = mode ? col_aux : inv;
                default:      rgb_out = rgb_in;
            endcase
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
// Top of the cursor overlay engine. Pixels enter with coordinates and
// leave one clock later, overlaid where they fall inside the cursor.
// The bitmap and the registers share one write port (see brief, R13).
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [RGB_W-1:0]   cfg_wdata,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [RGB_W-1:0]   pix_rgb,
    output logic               out_valid,
    output logic [RGB_W-1:0]   out_rgb
);
    logic [RGB_W-1:0]   col_first, col_second, col_aux;
    logic [DIM_W-1:0]   hot_x, hot_y;
    logic [COORD_W-1:0] pos_x, pos_y;
    logic               mode;
    logic [BMP_AW-1:0]  rd_addr;
    logic               valid_q, hit_q;
    logic [SEL_W-1:0]   sel_q;
    logic [RGB_W-1:0]   rgb_q;
    logic [BYTE_W-1:0]  bmp_byte;
    code_e              cur_code;
    logic               bmp_we;

    assign bmp_we = cfg_we && !cfg_addr[CFG_AW-1];

    cursor_regs #(.COORD_W(COORD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .col_first  (col_first),
        .col_second (col_second),
        .col_aux    (col_aux),
        .hot_x      (hot_x),
        .hot_y      (hot_y),
        .pos_x      (pos_x),
        .pos_y      (pos_y),
        .mode       (mode)
    );

    cursor_locate #(.COORD_W(COORD_W)) u_locate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_rgb   (pix_rgb),
        .hot_x     (hot_x),
        .hot_y     (hot_y),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .rd_addr   (rd_addr),
        .valid_q   (valid_q),
        .hit_q     (hit_q),
        .sel_q     (sel_q),
        .rgb_q     (rgb_q)
    );

    cursor_bitmap u_bitmap (
        .clk   (clk),
        .we    (bmp_we),
        .waddr (cfg_addr[BMP_AW-1:0]),
        .wdata (cfg_wdata[BYTE_W-1:0]),
        .re    (pix_valid),
        .raddr (rd_addr),
        .rdata (bmp_byte)
    );

    cursor_blend u_blend (
        .hit        (hit_q),
        .mode       (mode),
        .bmp_byte   (bmp_byte),
        .sel        (sel_q),
        .rgb_in     (rgb_q),
        .col_first  (col_first),
        .col_second (col_second),
        .col_aux    (col_aux),
        .code       (cur_code),
        .rgb_out    (out_rgb)
    );

    assign out_valid = valid_q;
endmodule

// File: rtl/cursor_overlay_chk.sv
// Property checker for cursor_overlay, attached by the bind below.
// Relates the registered pixel context, the fetched code and the output.
module cursor_overlay_chk
    import cursor_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              out_valid,
    input logic [RGB_W-1:0]  out_rgb,
    input logic              hit,
    input logic [CODE_W-1:0] code,
    input logic [RGB_W-1:0]  rgb_q,
    input logic              mode,
    input logic [RGB_W-1:0]  col_first,
    input logic [RGB_W-1:0]  col_second,
    input logic [RGB_W-1:0]  col_aux
);
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    p_hit_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> out_valid);

    p_outside_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !hit) |-> (out_rgb == rgb_q));

    p_second_colour_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hit && code == 2'b00) |-> (out_rgb == col_second));

    p_first_colour_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hit && code == 2'b01) |-> (out_rgb == col_first));

    p_clear_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hit && code == 2'b10) |-> (out_rgb == rgb_q));

    p_invert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hit && code == 2'b11 && !mode) |-> (out_rgb == ~rgb_q));

    p_aux_colour_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hit && code == 2'b11 && mode) |-> (out_rgb == col_aux));
endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .out_valid  (out_valid),
    .out_rgb    (out_rgb),
    .hit        (hit_q),
    .code       (cur_code),
    .rgb_q      (rgb_q),
    .mode       (mode),
    .col_first  (col_first),
    .col_second (col_second),
    .col_aux    (col_aux)
);

// File: tb/cursor_overlay_bench.sv
// Scoreboard bench: driver tasks predict each result from a shadow model
// built on the requirements and queue it; a monitor compares at negedge.
`timescale 1ns/1ps
module cursor_overlay_bench;
    localparam int CW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [CW-1:0] pix_x = '0;
    logic [CW-1:0] pix_y = '0;
    logic [23:0] pix_rgb = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // Shadow state of the configuration (requirement model)
    logic [7:0]  s_bmp [256];
    logic [23:0] s_first = '0, s_second = '0, s_aux = '0;
    int          s_hx = 0, s_hy = 0, s_px = 0, s_py = 0;
    logic        s_mode = 1'b0;

    logic [23:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    cursor_overlay #(.COORD_W(CW)) u_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_y(pix_y), .pix_rgb(pix_rgb), .out_valid(out_valid),
        .out_rgb(out_rgb)
    );

    function automatic logic [23:0] model(int x, int y, logic [23:0] rgb);
        int ox, oy, c, r;
        logic [1:0] code;
        ox = (s_px >= s_hx) ? s_px - s_hx : 0;   // R9, R10
        oy = (s_py >= s_hy) ? s_py - s_hy : 0;
        if (x < ox || x >= ox + 32 || y < oy || y >= oy + 32) return rgb; // R3, R11
        c = x - ox;
        r = y - oy;
        code = 2'((s_bmp[r*8 + c/4] >> (2*(c%4))) & 8'h3);            // R4
        case (code)
            2'b00:   return s_second;                                  // R5
            2'b01:   return s_first;
            2'b10:   return rgb;                                       // R6
            default: return s_mode ? s_aux : ~rgb;                     // R8, R7
        endcase
    endfunction

    task automatic shadow_update(input logic [8:0] a, input logic [23:0] d);
        if (!a[8]) s_bmp[a[7:0]] = d[7:0];
        else if (a[7:3] == 0) begin
            case (a[2:0])
                3'd0: s_first  = d;
                3'd1: s_second = d;
                3'd2: s_aux    = d;
                3'd3: begin s_hx = int'(d[4:0]); s_hy = int'(d[12:8]); end
                3'd4: s_px = int'(d[11:0]);
                3'd5: s_py = int'(d[11:0]);
                3'd6: s_mode = d[0];
                default: ;
            endcase
        end
    endtask

    // R13: configuration write through the shared port
    task automatic cfg_wr(input logic [8:0] a, input logic [23:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        shadow_update(a, d);
    endtask

    task automatic px(input int x, input int y, input logic [23:0] rgb, input string tag);
        pix_valid = 1'b1; pix_x = CW'(x); pix_y = CW'(y); pix_rgb = rgb;
        exp_q.push_back(model(x, y, rgb));
        tag_q.push_back(tag);
        @(posedge clk); #1;
        pix_valid = 1'b0;
    endtask

    // R12: pixel lookup and bitmap write on the same edge
    task automatic px_wr(input int x, input int y, input logic [23:0] rgb,
                         input logic [8:0] a, input logic [23:0] d, input string tag);
        pix_valid = 1'b1; pix_x = CW'(x); pix_y = CW'(y); pix_rgb = rgb;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        exp_q.push_back(model(x, y, rgb));
        tag_q.push_back(tag);
        @(posedge clk); #1;
        pix_valid = 1'b0; cfg_we = 1'b0;
        shadow_update(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    // Monitor: pop and compare each produced result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2: out_valid without a pending pixel, actual rgb %h expected none", out_rgb);
            end else begin
                automatic logic [23:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (out_rgb !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, out_rgb, e);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        tests++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid during reset actual %b expected 0", out_valid);
        end
        rst_n = 1'b1;
        idle(1);
        tests++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid after reset actual %b expected 0", out_valid);
        end

        // Fill bitmap with transparent codes
        for (int i = 0; i < 256; i++) cfg_wr(9'(i), 24'hAA);
        // R1: colour and placement registers reset to zero
        cfg_wr(9'h000, 24'h00);
        px(0, 0, 24'hABCDEF, "R1");

        // R13: colours and bitmap pattern
        cfg_wr(9'h100, 24'h112233);
        cfg_wr(9'h101, 24'h445566);
        cfg_wr(9'h102, 24'h778899);
        cfg_wr(9'h000, 24'hE4);          // cols 0..3: 00 01 10 11
        px(0, 0, 24'h0F0F0F, "R5");
        px(1, 0, 24'h0F0F0F, "R5");
        px(2, 0, 24'h13579B, "R6");
        px(3, 0, 24'h13579B, "R7");
        cfg_wr(9'h106, 24'h1);
        px(3, 0, 24'h13579B, "R8");
        cfg_wr(9'h106, 24'h0);

        // R4: byte ordering across rows and columns
        cfg_wr(9'h0FF, 24'h40);          // row 31 col 31 -> 01
        cfg_wr(9'h009, 24'h1B);          // row 1 cols 4..7: 11 10 01 00
        px(31, 31, 24'h202020, "R4");
        px(30, 31, 24'h202020, "R4");
        px(4, 1, 24'h303030, "R4");
        px(5, 1, 24'h303030, "R4");
        px(6, 1, 24'h303030, "R4");
        px(7, 1, 24'h303030, "R4");

        // R3: outside the window
        px(32, 0, 24'h5A5A5A, "R3");
        px(0, 32, 24'h5A5A5A, "R3");
        px(100, 200, 24'h5A5A5A, "R3");

        // R9: placement by hot spot
        cfg_wr(9'h103, {11'd0, 5'd7, 3'd0, 5'd5});
        cfg_wr(9'h104, 24'd100);
        cfg_wr(9'h105, 24'd50);
        px(95, 43, 24'h010203, "R9");
        px(96, 43, 24'h010203, "R9");
        px(100, 50, 24'h010203, "R9");
        px(94, 43, 24'h010203, "R9");
        px(126, 74, 24'h010203, "R9");
        px(127, 43, 24'h010203, "R9");

        // R10: clamp at left and top
        cfg_wr(9'h103, {11'd0, 5'd10, 3'd0, 5'd10});
        cfg_wr(9'h104, 24'd3);
        cfg_wr(9'h105, 24'd4);
        px(0, 0, 24'h0A0B0C, "R10");
        px(31, 31, 24'h0A0B0C, "R10");
        px(32, 31, 24'h0A0B0C, "R10");
        cfg_wr(9'h105, 24'd40);          // only x clamps
        px(0, 30, 24'h0A0B0C, "R10");
        px(0, 29, 24'h0A0B0C, "R10");

        // R11: clip at the far edges, no wrap
        cfg_wr(9'h103, 24'h0);
        cfg_wr(9'h002, 24'h00);          // row 0 cols 8..11 -> 00
        cfg_wr(9'h104, 24'd4090);
        cfg_wr(9'h105, 24'd4085);
        px(4090, 4085, 24'hC0C0C0, "R11");
        px(4095, 4085, 24'hC0C0C0, "R11");
        px(4, 4085, 24'hC0C0C0, "R11");
        px(4090, 5, 24'hC0C0C0, "R11");

        // R12: same-edge write and lookup of byte 0
        cfg_wr(9'h104, 24'd0);
        cfg_wr(9'h105, 24'd0);
        px_wr(0, 0, 24'h777777, 9'h000, 24'hAA, "R12");
        px(0, 0, 24'h777777, "R12");

        // R2: pixels with gaps then back to back
        px(1, 1, 24'h111111, "R2");
        idle(2);
        for (int i = 0; i < 6; i++) px(40 + i, 40, 24'h222222 + 24'(i), "R2");
        idle(3);

        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule